// File: doc/BRIEF.md
# Armed Pulse On-Time Meter

This block measures how long one drive pulse stays high, counted in cycles of the clock that also produces the pulse. A one-cycle start strobe arms it and latches which of several drive lines to watch. The first low-to-high transition of that line seen after arming clears the width counter and starts it. The first low sample after that ends the count, and the result is latched and announced with a one-cycle valid strobe. The pulse and the meter share one clock, so the count is exact to a single cycle.

An armed measurement is given a bounded window measured from the start strobe. If no complete pulse, rising and then falling, fits inside that window, the measurement is abandoned and a one-cycle timeout strobe is raised instead. A consumer that waits for either strobe therefore never hangs. A width much shorter than the commanded on-time tells the consumer that hardware current limiting cut the pulse. Judging that is left to the consumer.

Top module: `pw_meas`

## Requirements
- R1: During and right after reset, `valid_o` and `timeout_o` are 0 and `width_o` is 0.
- R2: After arming, `width_o` equals the number of consecutive clock edges at which the selected line was sampled high, counted from the first rising edge. `valid_o` is high for exactly the one cycle after the edge that first samples the line low again.
- R3: If the selected line is already high at the arming edge, that pulse is ignored. The line must go low and rise again before counting begins.
- R4: The line index on `pin_sel_i` is captured only with `start_i`. Activity on the other lines, and later changes of `pin_sel_i`, have no effect on the result.
- R5: Take the start edge as edge 0. If the falling sample has not occurred by edge `TIMEOUT_CYC`, `timeout_o` is high for the one cycle after edge `TIMEOUT_CYC` and `width_o` keeps its previous value.
- R6: A falling sample exactly at edge `TIMEOUT_CYC` still completes as valid, with no timeout.
- R7: The width count saturates at 2^`CNT_W`-1 and does not wrap.
- R8: Each arming produces at most one strobe, and `valid_o` and `timeout_o` are never high together. No strobe is produced without arming.
- R9: A start strobe while armed restarts the measurement. The pending pulse and the window in progress are abandoned without any strobe, and `start_i` takes priority over completion and timeout at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared with the drive pulses |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that arms a measurement |
| pin_sel_i | input | SEL_W | Index of the drive line to watch, captured with `start_i` |
| pulse_i | input | NUM_PINS | Drive lines, synchronous to `clk_i` |
| width_o | output | CNT_W | Last measured on-time in clock cycles |
| valid_o | output | 1 | One-cycle strobe: a new width was latched |
| timeout_o | output | 1 | One-cycle strobe: the measurement was abandoned |

## Verification
The falling sample that completes a pulse can land on the same edge where the window runs out. The sweep provokes this by stepping the gap before the pulse and its length, so that the falling sample lands before, exactly on, and after edge `TIMEOUT_CYC`. For every stimulus the bench computes, from the sampled waveform alone, which strobe must appear, the cycle it must appear in, and the width it must carry. The same sweep drives the unselected line with the inverse pattern and changes `pin_sel_i` after arming, so any leak from those inputs shows up as a wrong width.

// File: rtl/pw_meas_pkg.sv
package pw_meas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_pin_tap.sv
module pw_pin_tap #(
  parameter int unsigned NUM_PINS = 2,
  localparam int unsigned SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic                level_o,
  output logic                rise_o
);
  logic prev_q;
  logic new_lvl;

  generate
    if (NUM_PINS > 1) begin : g_multi
      logic [SEL_W-1:0] sel_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sel_q <= '0;
        else if (load_i) sel_q <= sel_i;
      end
      assign level_o = pins_i[sel_q];
      assign new_lvl = pins_i[sel_i];
    end else begin : g_single
      assign level_o = pins_i[0];
      assign new_lvl = pins_i[0] | (sel_i != sel_i);
    end
  endgenerate

  // on arming, history comes from the newly selected line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (load_i) prev_q <= new_lvl;
    else             prev_q <= level_o;
  end

  assign rise_o = level_o & ~prev_q;
endmodule

// File: rtl/pw_sat_cnt.sv
module pw_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_one_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (load_one_i)                 cnt_o <= CNT_W'(1);
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/pw_window.sv
module pw_window #(
  parameter int unsigned TIMEOUT_CYC = 170,
  localparam int unsigned TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic last_o
);
  localparam logic [TW-1:0] LAST_VAL = TW'(TIMEOUT_CYC - 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !last_o)    cnt_q <= cnt_q + TW'(1);
  end

  assign last_o = run_i && (cnt_q == LAST_VAL);
endmodule

// File: rtl/pw_meas.sv
module pw_meas
  import pw_meas_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 170,
  localparam int unsigned SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SEL_W-1:0]    pin_sel_i,
  input  logic [NUM_PINS-1:0] pulse_i,
  output logic [CNT_W-1:0]    width_o,
  output logic                valid_o,
  output logic                timeout_o
);
  pw_state_e        state_q, state_d;
  logic             level, rise, last;
  logic             armed;
  logic             cnt_load, cnt_inc;
  logic             done_ok, done_tmo;
  logic [CNT_W-1:0] cnt;

  assign armed = (state_q != ST_IDLE);

  pw_pin_tap #(.NUM_PINS(NUM_PINS)) u_tap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .sel_i   (pin_sel_i),
    .pins_i  (pulse_i),
    .level_o (level),
    .rise_o  (rise)
  );

  pw_window #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .run_i  (armed),
    .last_o (last)
  );

  pw_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_one_i (cnt_load),
    .inc_i      (cnt_inc),
    .cnt_o      (cnt)
  );

  // start beats completion and timeout; completion beats timeout
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_inc  = 1'b0;
    done_ok  = 1'b0;
    done_tmo = 1'b0;
    if (start_i) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (last) begin
            state_d  = ST_IDLE;
            done_tmo = 1'b1;
          end else if (rise) begin
            state_d  = ST_MEAS;
            cnt_load = 1'b1;
          end
        end
        ST_MEAS: begin
          if (!level) begin
            state_d = ST_IDLE;
            done_ok = 1'b1;
          end else if (last) begin
            state_d  = ST_IDLE;
            done_tmo = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      width_o   <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      valid_o   <= done_ok;
      timeout_o <= done_tmo;
      if (done_ok) width_o <= cnt;
    end
  end
endmodule

// File: rtl/pw_meas_chk.sv
module pw_meas_chk #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 170,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             armed,
  input logic [CNT_W-1:0] width_o,
  input logic             valid_o,
  input logic             timeout_o
);
  localparam logic [CW-1:0] LIM  = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] IDLE = CW'(TIMEOUT_CYC + 1);
  logic [CW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_q <= IDLE;
    else if (start_i)        since_q <= '0;
    else if (since_q < IDLE) since_q <= since_q + CW'(1);
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && timeout_o)); // R8
  AST_STROBE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || timeout_o) |-> $past(armed)); // R8
  AST_VALID_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_TMO_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R5
  AST_WIDTH_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (width_o != '0)); // R2
  AST_WIDTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(width_o)); // R5
  AST_TMO_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (since_q == LIM)); // R5
  AST_VALID_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (since_q >= CW'(2) && since_q <= LIM)); // R6
endmodule

bind pw_meas pw_meas_chk #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .armed     (armed),
  .width_o   (width_o),
  .valid_o   (valid_o),
  .timeout_o (timeout_o)
);

// File: tb/pw_meas_test.sv
`timescale 1ns/1ps
module pw_meas_test;
  localparam int NP = 2;
  localparam int W  = 4;
  localparam int T  = 24;
  localparam int N  = T + 4;
  localparam int WMAX = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [0:0]    pin_sel_i = '0;
  logic [NP-1:0] pulse_i = '0;
  logic [W-1:0]  width_o;
  logic          valid_o, timeout_o;

  int tests = 0, fails = 0;
  int n_v, n_t, j_v, j_t, w_seen;
  int prev_w = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pw_meas #(.NUM_PINS(NP), .CNT_W(W), .TIMEOUT_CYC(T)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pin_sel_i(pin_sel_i),
    .pulse_i(pulse_i), .width_o(width_o), .valid_o(valid_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_obs();
    n_v = 0; n_t = 0; j_v = -1; j_t = -1; w_seen = -1;
  endtask

  task automatic step(input bit st, input logic [0:0] sel, input logic [NP-1:0] pins, input int j);
    @(negedge clk);
    start_i = st; pin_sel_i = sel; pulse_i = pins;
    @(posedge clk); #1;
    if (valid_o)   begin n_v++; j_v = j; w_seen = int'(width_o); end
    if (timeout_o) begin n_t++; j_t = j; end
  endtask

  task automatic run_case(input int sel, input bit lead, input int gap, input int hi);
    bit p [N];
    int k, jr, jf, ew;
    bit ev;
    string tag;
    logic [NP-1:0] pins;
    for (int j = 0; j < N; j++) p[j] = 1'b0;
    k = 0;
    if (lead) begin
      for (int j = 0; j < 3; j++) p[j] = 1'b1;
      k = 3;
    end
    k += gap;
    for (int j = 0; j < hi; j++) if (k + j < N) p[k + j] = 1'b1;
    // expected outcome from the waveform alone
    jr = -1; jf = -1;
    for (int j = 1; j < N; j++) begin
      if (jr < 0 && p[j] && !p[j-1]) jr = j;
      else if (jr >= 0 && jf < 0 && !p[j]) jf = j;
    end
    ev = (jf > 0) && (jf <= T);
    ew = ev ? ((jf - jr > WMAX) ? WMAX : jf - jr) : prev_w;
    if (!ev)                      tag = "R5";
    else if (jf - jr > WMAX)      tag = "R7";
    else if (jf == T)             tag = "R6";
    else if (lead)                tag = "R3";
    else if (sel != 0)            tag = "R4";
    else                          tag = "R2";
    clr_obs();
    for (int j = 0; j < N; j++) begin
      pins = {NP{~p[j]}};
      pins[sel] = p[j];
      step(j == 0, (j == 0) ? 1'(sel) : 1'(~sel), pins, j);
    end
    chk(n_v == int'(ev), {tag, " valid count"}, n_v, int'(ev));
    chk(n_t == int'(!ev), {"R8 ", tag, " timeout count"}, n_t, int'(!ev));
    chk(int'(width_o) == ew, {tag, " width"}, int'(width_o), ew);
    if (ev) chk(j_v == jf, {tag, " valid cycle"}, j_v, jf);
    else    chk(j_t == T, "R5 timeout cycle", j_t, T);
    prev_w = ew;
  endtask

  initial begin
    #3;
    // R1
    chk(valid_o == 1'b0 && timeout_o == 1'b0, "R1 strobes in reset", int'(valid_o | timeout_o), 0);
    chk(width_o == '0, "R1 width in reset", int'(width_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(valid_o == 1'b0 && timeout_o == 1'b0 && width_o == '0, "R1 after release", int'(width_o), 0);

    // R8: no strobe without arming
    clr_obs();
    for (int j = 0; j < 30; j++) step(1'b0, 1'(j), NP'(j), j);
    chk(n_v + n_t == 0, "R8 idle strobes", n_v + n_t, 0);

    // R9: restart while measuring
    clr_obs();
    step(1'b1, 1'b0, 2'b00, 0);
    step(1'b0, 1'b0, 2'b01, 1);
    step(1'b0, 1'b0, 2'b01, 2);
    step(1'b0, 1'b0, 2'b01, 3);
    step(1'b1, 1'b0, 2'b01, 4);
    step(1'b0, 1'b0, 2'b01, 5);
    for (int j = 6; j < 9; j++) step(1'b0, 1'b0, 2'b00, j);
    for (int j = 9; j < 14; j++) step(1'b0, 1'b0, 2'b01, j);
    for (int j = 14; j < 14 + T; j++) step(1'b0, 1'b0, 2'b00, j);
    chk(n_v == 1, "R9 one valid after restart", n_v, 1);
    chk(n_t == 0, "R9 no timeout after restart", n_t, 0);
    chk(int'(width_o) == 5, "R9 width of next pulse", int'(width_o), 5);
    chk(j_v == 14, "R9 valid cycle", j_v, 14);
    prev_w = int'(width_o);

    // sweep
    for (int sel = 0; sel < NP; sel++)
      for (int lead = 0; lead < 2; lead++)
        for (int gap = 0; gap < 7; gap++)
          for (int hi = 1; hi <= 22; hi++)
            run_case(sel, 1'(lead), gap, hi);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule